// File: doc/BRIEF.md
# Automatic Clock Gating Controller

This block decides, cycle by cycle, whether the internal clocks of a serial bus communication controller may be switched off to save power. It runs on an always-on clock. It watches a fixed set of activity and mode inputs: frame activity on the bus, message buffer transfers, frames waiting to be transmitted, host register access, debug mode, low-power stop mode and the bus-off state. Gating is allowed only while all of those inputs report idle and a software enable bit is set.

The block drives a registered clock-enable toward an external gating cell, so the enable only changes between active edges. It also reports whether the clocks are gated off right now. Two inputs arrive from other clock domains: bus activity and host access. Each of them passes through a synchronizer chain before it takes part in the decision. The conditions are checked again on every cycle, so the clocks can stop and restart any number of times without software help.

Top module: `acg_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `clk_en_o` is 1 and `gated_o` is 0.
- R2: When `aps_en_i` is 0 at a clock edge, `clk_en_o` is 1 after that edge, whatever the other inputs are. Setting `aps_en_i` to 0 while the clocks are gated restarts them after one edge.
- R3: When `aps_en_i` is 1 and every condition input reports idle (all 0), `clk_en_o` goes to 0 and `gated_o` goes to 1 one edge after the last synchronous condition became idle.
- R4: Bus frame activity (`frame_act_i`, asynchronous) passes through a chain of SYNC_STAGES flops (default 2). A level change on it reaches `clk_en_o` on the third clock edge after the change. While it is 1, the clocks are not gated.
- R5: Host access (`host_acc_i`, asynchronous) uses the same synchronizer and has the same three-edge latency. While it is 1, the clocks are not gated.
- R6: A message buffer transfer (`xfer_act_i`) or a frame waiting for transmission (`tx_wait_i`) raises `clk_en_o` one edge after it appears, and holds it high while present.
- R7: Debug mode (`dbg_mode_i`), stop mode (`stop_mode_i`) or bus-off (`bus_off_i`) raises `clk_en_o` one edge after it appears, and holds it high while present.
- R8: After a restart, the block keeps checking the conditions and gates the clocks again once all of them are idle, over repeated stop and restart rounds.
- R9: `gated_o` is always the complement of `clk_en_o`, and both change on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aps_en_i | input | 1 | Software enable for automatic gating |
| frame_act_i | input | 1 | Receive or transmit frame in progress (asynchronous) |
| host_acc_i | input | 1 | Host access to the module in progress (asynchronous) |
| xfer_act_i | input | 1 | Frame moving into or out of a message buffer |
| tx_wait_i | input | 1 | At least one buffer holds a frame awaiting transmission |
| dbg_mode_i | input | 1 | Module is in debug mode |
| stop_mode_i | input | 1 | Module is in low-power stop mode |
| bus_off_i | input | 1 | Module is in the bus-off state |
| clk_en_o | output | 1 | Registered clock enable toward the gating cell (1 = clocks run) |
| gated_o | output | 1 | Status: clocks currently gated off |

## Verification
The assertions check the following on every cycle:
- A cleared enable, any synchronous busy condition, or a synchronized busy flag forces the enable high on the next edge.
- A fully idle, enabled cycle gates the clocks on the next edge.
- The status output always mirrors the enable.

Only the bench scenarios show the following:
- The three-edge latency through the synchronizers on the asynchronous inputs.
- The reset state.
- Gating and restart repeated over several rounds with different inputs as the cause.

// File: rtl/acg_pkg.sv
package acg_pkg;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_GATED = 1'b1
    } acg_state_e;

    // one bit per reason that keeps the clocks running
    typedef struct packed {
        logic frame_act;
        logic host_acc;
        logic xfer_act;
        logic tx_wait;
        logic dbg_mode;
        logic stop_mode;
        logic bus_off;
    } acg_cond_t;

    localparam int unsigned ACG_NCOND = $bits(acg_cond_t);

    typedef struct packed {
        acg_state_e state;
        logic       clk_en;
    } acg_seq_t;

endpackage

// File: rtl/acg_sync.sv
module acg_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stage_d[s] = async_i;
            end else begin : g_next
                assign stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= {WIDTH{RST_VAL}};
                end else begin
                    stage_q[s] <= stage_d[s];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/acg_idle_eval.sv
module acg_idle_eval
    import acg_pkg::*;
(
    input  acg_cond_t cond_i,
    output logic      all_idle_o
);

    logic [ACG_NCOND-1:0] busy_vec;

    assign busy_vec = cond_i;

    always_comb begin
        all_idle_o = 1'b1;
        for (int i = 0; i < int'(ACG_NCOND); i++) begin
            if (busy_vec[i]) begin
                all_idle_o = 1'b0;
            end
        end
    end

endmodule

// File: rtl/acg_seq.sv
module acg_seq
    import acg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic aps_en_i,
    input  logic all_idle_i,
    output logic clk_en_o,
    output logic gated_o
);

    acg_seq_t seq_d;
    acg_seq_t seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!aps_en_i) begin
            seq_d.state = ST_RUN;
        end else if (all_idle_i) begin
            seq_d.state = ST_GATED;
        end else begin
            seq_d.state = ST_RUN;
        end
        seq_d.clk_en = (seq_d.state == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state  <= ST_RUN;
            seq_q.clk_en <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign clk_en_o = seq_q.clk_en;
    assign gated_o  = (seq_q.state == ST_GATED);

endmodule

// File: rtl/acg_ctrl.sv
module acg_ctrl
    import acg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aps_en_i,
    input  logic frame_act_i,
    input  logic host_acc_i,
    input  logic xfer_act_i,
    input  logic tx_wait_i,
    input  logic dbg_mode_i,
    input  logic stop_mode_i,
    input  logic bus_off_i,
    output logic clk_en_o,
    output logic gated_o
);

    localparam int unsigned NASYNC = 2;

    logic [NASYNC-1:0] async_raw;
    logic [NASYNC-1:0] async_s;
    logic              frame_s;
    logic              host_s;
    acg_cond_t         cond;
    logic              all_idle;

    assign async_raw = {frame_act_i, host_acc_i};

    // reset to busy so nothing gates before real values arrive
    acg_sync #(
        .WIDTH   (NASYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_raw),
        .sync_o  (async_s)
    );

    assign frame_s = async_s[1];
    assign host_s  = async_s[0];

    always_comb begin
        cond.frame_act = frame_s;
        cond.host_acc  = host_s;
        cond.xfer_act  = xfer_act_i;
        cond.tx_wait   = tx_wait_i;
        cond.dbg_mode  = dbg_mode_i;
        cond.stop_mode = stop_mode_i;
        cond.bus_off   = bus_off_i;
    end

    acg_idle_eval u_eval (
        .cond_i     (cond),
        .all_idle_o (all_idle)
    );

    acg_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .aps_en_i   (aps_en_i),
        .all_idle_i (all_idle),
        .clk_en_o   (clk_en_o),
        .gated_o    (gated_o)
    );

endmodule

// File: rtl/acg_ctrl_chk.sv
module acg_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic aps_en_i,
    input logic frame_s,
    input logic host_s,
    input logic xfer_act_i,
    input logic tx_wait_i,
    input logic dbg_mode_i,
    input logic stop_mode_i,
    input logic bus_off_i,
    input logic clk_en_o,
    input logic gated_o
);

    AST_DISABLE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        !aps_en_i |=> clk_en_o); // R2

    AST_IDLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (aps_en_i && !frame_s && !host_s && !xfer_act_i && !tx_wait_i &&
         !dbg_mode_i && !stop_mode_i && !bus_off_i) |=> !clk_en_o); // R3

    AST_FRAME_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_s |=> clk_en_o); // R4

    AST_HOST_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        host_s |=> clk_en_o); // R5

    AST_XFER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_act_i || tx_wait_i) |=> clk_en_o); // R6

    AST_MODE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode_i || stop_mode_i || bus_off_i) |=> clk_en_o); // R7

    AST_STATUS_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        gated_o != clk_en_o); // R9

endmodule

bind acg_ctrl acg_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .aps_en_i    (aps_en_i),
    .frame_s     (frame_s),
    .host_s      (host_s),
    .xfer_act_i  (xfer_act_i),
    .tx_wait_i   (tx_wait_i),
    .dbg_mode_i  (dbg_mode_i),
    .stop_mode_i (stop_mode_i),
    .bus_off_i   (bus_off_i),
    .clk_en_o    (clk_en_o),
    .gated_o     (gated_o)
);

// File: tb/acg_ctrl_tb.sv
`timescale 1ns/1ps
module acg_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n;
    logic aps_en, frame_act, host_acc, xfer_act, tx_wait, dbg_mode, stop_mode, bus_off;
    logic clk_en, gated;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    acg_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .aps_en_i    (aps_en),
        .frame_act_i (frame_act),
        .host_acc_i  (host_acc),
        .xfer_act_i  (xfer_act),
        .tx_wait_i   (tx_wait),
        .dbg_mode_i  (dbg_mode),
        .stop_mode_i (stop_mode),
        .bus_off_i   (bus_off),
        .clk_en_o    (clk_en),
        .gated_o     (gated)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // clk_en and its complement status together
    task automatic chk_en(input string req, input logic exp_en);
        chk(req, clk_en, exp_en);
        chk({req, " status"}, gated, ~exp_en);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic all_idle();
        frame_act = 0; host_acc = 0; xfer_act = 0; tx_wait = 0;
        dbg_mode = 0; stop_mode = 0; bus_off = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; aps_en = 1; all_idle();
        step(2);
        chk_en("R1 in reset", 1'b1);
        rst_n = 1;
        step(1);
        chk_en("R1 first cycle", 1'b1);
        step(3);
        chk_en("R3 gated after reset", 1'b0);
    endtask

    task automatic t_disable();
        aps_en = 0;
        step(1);
        chk_en("R2 disable restarts", 1'b1);
        step(5);
        chk_en("R2 stays running", 1'b1);
        aps_en = 1;
        step(1);
        chk_en("R3 re-enable gates", 1'b0);
    endtask

    task automatic t_sync_cond(input string req, input int which);
        case (which)
            0: xfer_act = 1; 1: tx_wait = 1; 2: dbg_mode = 1;
            3: stop_mode = 1; default: bus_off = 1;
        endcase
        chk_en({req, " before edge"}, 1'b0);
        step(1);
        chk_en({req, " restart"}, 1'b1);
        step(2);
        chk_en({req, " held"}, 1'b1);
        all_idle();
        step(1);
        chk_en("R8 gates again", 1'b0);
    endtask

    task automatic t_async_cond(input string req, input bit use_host);
        if (use_host) host_acc = 1; else frame_act = 1;
        step(2);
        chk_en({req, " not yet"}, 1'b0);
        step(1);
        chk_en({req, " restart on third edge"}, 1'b1);
        if (use_host) host_acc = 0; else frame_act = 0;
        step(2);
        chk_en({req, " still running"}, 1'b1);
        step(1);
        chk_en({req, " regate on third edge"}, 1'b0);
    endtask

    task automatic t_disable_busy();
        tx_wait = 1; aps_en = 0;
        step(1);
        chk_en("R2 disabled with busy", 1'b1);
        tx_wait = 0;
        step(3);
        chk_en("R2 disabled while idle", 1'b1);
        aps_en = 1;
        step(1);
        chk_en("R8 regate after enable", 1'b0);
    endtask

    task automatic t_rounds();
        for (int r = 0; r < 4; r++) begin
            dbg_mode = 1;
            step(1);
            chk_en("R8 round restart", 1'b1);
            dbg_mode = 0;
            step(1);
            chk_en("R8 round regate", 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_disable();
        t_sync_cond("R6 xfer", 0);
        t_sync_cond("R6 tx_wait", 1);
        t_sync_cond("R7 debug", 2);
        t_sync_cond("R7 stop", 3);
        t_sync_cond("R7 bus_off", 4);
        t_async_cond("R4 frame", 1'b0);
        t_async_cond("R5 host", 1'b1);
        t_disable_busy();
        t_rounds();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule